// File: doc/BRIEF.md
# Dirty-Half Eviction Write-Back Buffer

This block sits between a data cache and the memory side. When the cache evicts a victim line during a linefill, or cleans a dirty line, it hands over the line in one cycle. The handover carries eight data words, the line base address and one dirty flag for each four-word half. The buffer keeps that single line and its single address. It then writes back only the dirty parts as word writes on a valid/ready memory port: the whole line, one half, or nothing.

A busy output tells the cache when it must not hand over another victim. A handover offered while the buffer is busy waits until the buffer is free, and it is never lost. A line with no dirty half is retired in the cycle it is accepted and causes no memory traffic.

Top module: `evict_wbuf`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied. After that edge `busy` and `mem_valid` are low and `ld_ready` is high.
- R2: `ld_ready` equals the inverse of `busy`. A line is captured at a rising edge where `ld_valid` and `ld_ready` are both high. The capture takes all eight words of `ld_line` (word k in bits [32k+31:32k]), `ld_addr` and `ld_dirty`.
- R3: `ld_dirty` = 2'b11 produces exactly eight memory writes, covering words 0 through 7.
- R4: `ld_dirty` bit 0 marks words 0–3 and bit 1 marks words 4–7. With exactly one bit set, exactly the four words of that half are written. No word of a clean half is ever requested.
- R5: `ld_dirty` = 2'b00 issues no memory request and leaves `busy` low. A further line can be accepted in the very next cycle.
- R6: Writes leave in ascending word order, one per accepted handshake (`mem_valid` and `mem_ready` high at an edge). `mem_addr` is the captured base plus four times the word index, and `mem_data` is that word.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R8: `busy` rises in the cycle after a dirty line is accepted. It falls in the cycle after the last required word is accepted. A line offered while `busy` is high is stalled and accepted once `busy` falls, and it is then written back in full.
- R9: A reset during a write-back drops the remaining words. The next line loaded afterwards is written back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Cache offers a victim line |
| ld_ready | output | 1 | Buffer can take a line this cycle |
| ld_addr | input | 32 | Line base address |
| ld_line | input | 256 | Eight data words, word k at bits [32k+31:32k] |
| ld_dirty | input | 2 | Dirty flag per half: bit 0 words 0–3, bit 1 words 4–7 |
| busy | output | 1 | A write-back is in progress |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_addr | output | 32 | Byte address of the word being written |
| mem_data | output | 32 | Data of the word being written |

## Verification
A line accepted at edge N shows `busy` and its first request one edge later. Each request advances one edge after the handshake that accepts it. `busy` falls one edge after the final handshake, and a clean line leaves `busy` low at edge N+1. The bench drives every input on the falling edge and reads every output on the falling edge that follows the edge where the value is due. It records each handshake at the falling edge before the rising edge that completes it, and compares the recorded address and data list with the list of words it derives from the dirty mask. Vectors stretch the handshake with different `mem_ready` patterns so that the request-hold and ordering rules are checked across stalls.

// File: rtl/evict_pkg.sv
package evict_pkg;
   typedef enum logic {
      EV_IDLE  = 1'b0,
      EV_DRAIN = 1'b1
   } ev_state_t;
endpackage

// File: rtl/evict_pick.sv
// Finds the lowest word index at or above a start point whose segment is dirty.
module evict_pick #(
   parameter int LINE_WORDS = 8,
   parameter int SEGS       = 2,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int SEG_WORDS = LINE_WORDS / SEGS
) (
   input  logic [SEGS-1:0]  mask,
   input  logic [IDX_W:0]   start,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = LINE_WORDS - 1; i >= 0; i--) begin
         if ((i >= int'(start)) && mask[i / SEG_WORDS]) begin
            found = 1'b1;
            idx   = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/evict_store.sv
// Holds one victim line and its base address; presents the selected word.
module evict_store #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 8,
   localparam int IDX_W     = $clog2(LINE_WORDS)
) (
   input  logic                         clk,
   input  logic                         load,
   input  logic [LINE_WORDS*DATA_W-1:0] din,
   input  logic [ADDR_W-1:0]            addr_in,
   input  logic [IDX_W-1:0]             sel,
   output logic [DATA_W-1:0]            dout,
   output logic [ADDR_W-1:0]            base
);
   logic [DATA_W-1:0] words [LINE_WORDS];

   always_ff @(posedge clk) begin
      if (load) begin
         base <= addr_in;
         for (int k = 0; k < LINE_WORDS; k++)
            words[k] <= din[k*DATA_W +: DATA_W];
      end
   end

   assign dout = words[sel];
endmodule

// File: rtl/evict_seq.sv
// Write-back sequencer: walks dirty words in ascending order.
module evict_seq
   import evict_pkg::*;
#(
   parameter int LINE_WORDS = 8,
   parameter int SEGS       = 2,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int SEG_SH    = $clog2(LINE_WORDS / SEGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_fire,
   input  logic [SEGS-1:0]  ld_dirty,
   input  logic             first_found,
   input  logic [IDX_W-1:0] first_idx,
   input  logic             next_found,
   input  logic [IDX_W-1:0] next_idx,
   input  logic             mem_fire,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic [SEGS-1:0]  dirty_q
);
   ev_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= EV_IDLE;
         idx     <= '0;
         dirty_q <= '0;
      end else begin
         case (state)
            EV_IDLE: begin
               if (ld_fire && first_found) begin
                  state   <= EV_DRAIN;
                  idx     <= first_idx;
                  dirty_q <= ld_dirty;
               end
            end
            EV_DRAIN: begin
               if (mem_fire) begin
                  if (next_found) begin
                     idx <= next_idx;
                  end else begin
                     state   <= EV_IDLE;
                     dirty_q <= '0;
                  end
               end
            end
            default: state <= EV_IDLE;
         endcase
      end
   end

   assign busy = (state == EV_DRAIN);

   AST_CLEAN_SEG_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> dirty_q[idx >> SEG_SH]);  // R4

   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_fire && next_found) |=> (idx > $past(idx)));  // R6

   AST_CLEAN_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && ld_dirty == '0) |=> !busy);  // R5
endmodule

// File: rtl/evict_wbuf.sv
module evict_wbuf #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int SEGS       = 2,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int BYTE_SH   = $clog2(DATA_W / 8),
   localparam int LINE_W    = LINE_WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LINE_W-1:0] ld_line,
   input  logic [SEGS-1:0]   ld_dirty,
   output logic              busy,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (SEGS < 1 || LINE_WORDS % SEGS != 0) begin : g_bad_segs
      $error("SEGS must divide LINE_WORDS");
   end

   logic              ld_fire, mem_fire;
   logic              first_found, next_found;
   logic [IDX_W-1:0]  first_idx, next_idx, idx;
   logic [SEGS-1:0]   dirty_q;
   logic [ADDR_W-1:0] base;

   assign ld_ready  = !busy;
   assign ld_fire   = ld_valid && ld_ready;
   assign mem_valid = busy;
   assign mem_fire  = mem_valid && mem_ready;

   evict_pick #(.LINE_WORDS(LINE_WORDS), .SEGS(SEGS)) u_first (
      .mask(ld_dirty), .start('0), .found(first_found), .idx(first_idx));

   evict_pick #(.LINE_WORDS(LINE_WORDS), .SEGS(SEGS)) u_next (
      .mask(dirty_q), .start({1'b0, idx} + 1'b1), .found(next_found), .idx(next_idx));

   evict_seq #(.LINE_WORDS(LINE_WORDS), .SEGS(SEGS)) u_seq (
      .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_dirty(ld_dirty),
      .first_found(first_found), .first_idx(first_idx),
      .next_found(next_found), .next_idx(next_idx),
      .mem_fire(mem_fire), .busy(busy), .idx(idx), .dirty_q(dirty_q));

   evict_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_store (
      .clk(clk), .load(ld_fire), .din(ld_line), .addr_in(ld_addr),
      .sel(idx), .dout(mem_data), .base(base));

   assign mem_addr = base + (ADDR_W'(idx) << BYTE_SH);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));  // R7

   AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(base));  // R8
endmodule

// File: tb/sim_evict_wbuf.sv
module sim_evict_wbuf;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_valid = 1'b0;
   logic         ld_ready;
   logic [31:0]  ld_addr = '0;
   logic [255:0] ld_line = '0;
   logic [1:0]   ld_dirty = '0;
   logic         busy, mem_valid;
   logic         mem_ready = 1'b0;
   logic [31:0]  mem_addr, mem_data;

   int tests = 0;
   int fails = 0;

   logic [31:0] got_a [16];
   logic [31:0] got_d [16];
   int          got_n;
   int          drain_cyc;

   always #5 clk = ~clk;

   evict_wbuf u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
      .ld_addr(ld_addr), .ld_line(ld_line), .ld_dirty(ld_dirty), .busy(busy),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_data(mem_data));

   // fields: [37:36] dirty, [35:32] ready pattern, [31:0] base
   localparam logic [37:0] VEC [7] = '{
      {2'b11, 4'b1111, 32'h1000_0000},
      {2'b01, 4'b1111, 32'h2000_0020},
      {2'b10, 4'b1010, 32'h3000_0040},
      {2'b11, 4'b0110, 32'h4000_1FE0},
      {2'b00, 4'b1111, 32'h5000_0000},
      {2'b10, 4'b1111, 32'h6000_0100},
      {2'b01, 4'b0011, 32'h7000_0060}
   };

   function automatic logic [31:0] wd(input logic [31:0] b, input int k);
      return b ^ (32'h0101_0101 * (k + 3)) ^ 32'h5A00_00A5;
   endfunction

   function automatic logic [255:0] mkline(input logic [31:0] b);
      logic [255:0] l;
      for (int k = 0; k < 8; k++) l[k*32 +: 32] = wd(b, k);
      return l;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // present a line at a falling edge; it is taken at the next rising edge if ld_ready
   task automatic offer(input logic [31:0] b, input logic [1:0] d);
      ld_addr  = b;
      ld_line  = mkline(b);
      ld_dirty = d;
      ld_valid = 1'b1;
   endtask

   task automatic drain(input logic [3:0] pat);
      bit          stalled = 1'b0;
      logic [31:0] pa = '0, pd = '0;
      got_n = 0;
      drain_cyc = 0;
      while (busy && drain_cyc < 200) begin
         if (stalled)
            chk(mem_valid && mem_addr == pa && mem_data == pd, "R7 held request", mem_addr, pa);
         mem_ready = pat[drain_cyc % 4];
         if (mem_valid && mem_ready && got_n < 16) begin
            got_a[got_n] = mem_addr;
            got_d[got_n] = mem_data;
            got_n++;
         end
         stalled = mem_valid && !mem_ready;
         pa = mem_addr;
         pd = mem_data;
         @(negedge clk);
         drain_cyc++;
      end
      mem_ready = 1'b0;
   endtask

   task automatic compare(input logic [31:0] b, input logic [1:0] d, input string req);
      int n = 0;
      for (int k = 0; k < 8; k++) if (d[k/4]) n++;
      chk(got_n == n, {req, " word count"}, got_n, n);
      n = 0;
      for (int k = 0; k < 8; k++) begin
         if (d[k/4]) begin
            if (n < got_n) begin
               chk(got_a[n] == b + 32'(4*k), "R6 address order", got_a[n], b + 32'(4*k));
               chk(got_d[n] == wd(b, k), "R6 data", got_d[n], wd(b, k));
            end
            n++;
         end
      end
      chk(drain_cyc < 200 && !busy, "R8 busy falls after last word", busy, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !mem_valid && ld_ready, "R1 reset state", {busy, mem_valid, ld_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table
      foreach (VEC[v]) begin
         logic [1:0]  d;
         logic [3:0]  p;
         logic [31:0] b;
         {d, p, b} = VEC[v];
         offer(b, d);
         chk(ld_ready, "R2 ready when idle", ld_ready, 1);
         @(negedge clk);
         ld_valid = 1'b0;
         if (d == 2'b00) begin
            chk(!busy && !mem_valid, "R5 clean line no request", {busy, mem_valid}, 0);
            chk(ld_ready, "R5 next load accepted at once", ld_ready, 1);
         end else begin
            chk(busy && !ld_ready, "R8 busy after accept", busy, 1);
         end
         drain(p);
         compare(b, d, d == 2'b11 ? "R3 full line" : (d == 2'b00 ? "R5 none" : "R4 half line"));
         @(negedge clk);
      end

      // R8: load offered while busy is stalled, then taken
      offer(32'h8000_0000, 2'b11);
      @(negedge clk);
      offer(32'h9000_0080, 2'b10);
      chk(!ld_ready, "R8 stalled while busy", ld_ready, 0);
      drain(4'b1111);
      compare(32'h8000_0000, 2'b11, "R3 first of pair");
      chk(ld_valid && ld_ready, "R8 stalled line pending", ld_ready, 1);
      @(negedge clk);
      ld_valid = 1'b0;
      chk(busy, "R8 stalled line accepted", busy, 1);
      drain(4'b1111);
      compare(32'h9000_0080, 2'b10, "R8 stalled line written");

      // R5: two clean lines back to back, then a dirty one
      offer(32'hA000_0000, 2'b00);
      @(negedge clk);
      chk(ld_ready && !mem_valid, "R5 back-to-back clean", ld_ready, 1);
      offer(32'hA000_0020, 2'b01);
      @(negedge clk);
      ld_valid = 1'b0;
      drain(4'b1111);
      compare(32'hA000_0020, 2'b01, "R4 after clean");

      // R9: reset in the middle of a write-back
      offer(32'hB000_0000, 2'b11);
      @(negedge clk);
      ld_valid = 1'b0;
      mem_ready = 1'b1;
      repeat (2) @(negedge clk);
      mem_ready = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !mem_valid && ld_ready, "R9 reset empties buffer", {busy, mem_valid, ld_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_valid, "R9 no leftover words", mem_valid, 0);
      offer(32'hC000_0040, 2'b01);
      @(negedge clk);
      ld_valid = 1'b0;
      drain(4'b1101);
      compare(32'hC000_0040, 2'b01, "R9 load after reset");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule